// File: doc/BRIEF.md
# Warp Load Coalescer

This block takes one load request from a whole warp and turns it into as few aligned memory transactions as it can. The request is a set of per-lane byte addresses, each naming a 4-byte element, and an active-lane mask. The block groups the active lanes by aligned memory segment. The segment is 4 bytes times the warp width: 128 bytes for 32 lanes and 256 bytes for 64 lanes. It emits one transaction per segment touched. Each transaction carries the segment base address and a mask of the lanes it serves.

When the lanes read consecutive elements from an aligned base, the whole warp is served by one wide transaction. When every lane lands in a different segment, one transaction per lane comes out. Transactions leave one at a time over a valid/ready handshake. In each cycle, the lowest-numbered lane that is still pending picks the segment, and every pending lane in that segment retires with it. A one-cycle done pulse closes the request. A new request is taken only after that pulse.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready is 1, and txn_valid and done are 0.
- R2: txn_base is the leading lane's address with its low log2(4*LANES) bits cleared, so it is always aligned to the segment size of 4*LANES bytes.
- R3: Each transaction's segment is chosen by the lowest-numbered pending lane. Bit N of txn_lanes is set exactly when lane N is pending and its address lies in that segment. Lanes retired by a handshake never appear again.
- R4: When the base is segment-aligned and every lane N of a full mask addresses base + 4*N, exactly one transaction is produced, with all lane bits set.
- R5: When every active lane addresses a different segment, one transaction per active lane is produced, in ascending lane order.
- R6: A lane whose mask bit (bit N = lane N) is 0 never appears in txn_lanes, and its address has no effect on the transactions.
- R7: A request with an all-zero mask produces no transaction, and done is high in the first cycle after acceptance.
- R8: While txn_valid is high and txn_ready is low, txn_valid, txn_base and txn_lanes hold their values.
- R9: done is a one-cycle pulse in the cycle after the last transaction handshake. req_ready returns to 1 in the cycle after done.
- R10: A request is accepted on a clock edge with req_valid and req_ready both high. req_ready stays 0 from acceptance until the cycle after done, and no transaction or done is presented while req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | LANES*AW | Per-lane byte addresses, lane N in bits [N*AW +: AW] |
| req_mask | input | LANES | Active lanes, bit N = lane N |
| txn_valid | output | 1 | Transaction presented |
| txn_ready | input | 1 | Memory side takes the transaction |
| txn_base | output | AW | Segment-aligned base address |
| txn_lanes | output | LANES | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse when the request is fully covered |

## Verification
The first transaction is presented in the cycle after acceptance, because the request is captured in one register stage. A new transaction follows in the cycle after each handshake. done rises one cycle after the last handshake, or one cycle after acceptance when the mask is empty, and req_ready returns one cycle after done. The bench drives and samples on the falling edge. For each cycle it records which outputs are due. It compares each handshaked transaction against an expected list built from the requirements, and it checks that done arrives exactly one cycle after the last handshake it counted. Stalled runs toggle txn_ready to confirm that a held transaction is neither lost nor repeated.

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES-1:0]    req_mask,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_base,
  output logic [LANES-1:0]    txn_lanes,
  output logic                done
);
  localparam int SEG_LSB = $clog2(4 * LANES);
  localparam int SW      = AW - SEG_LSB;
  localparam int LW      = $clog2(LANES);

  logic                busy;
  logic [LANES*SW-1:0] seg_in, seg_q;
  logic [LANES-1:0]    pend_q, hit, unused_off;
  logic [LW-1:0]       lead;
  logic [SW-1:0]       lead_seg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign seg_in[g*SW +: SW] = req_addr[g*AW+SEG_LSB +: SW];
    assign unused_off[g]      = ^req_addr[g*AW +: SEG_LSB];
    assign hit[g]             = pend_q[g] && (seg_q[g*SW +: SW] == lead_seg);
  end

  always_comb begin
    lead = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (pend_q[i]) lead = LW'(i);
  end

  assign lead_seg  = seg_q[int'(lead)*SW +: SW];
  assign req_ready = !busy;
  assign txn_valid = busy && (pend_q != '0);
  assign done      = busy && (pend_q == '0);
  assign txn_base  = {lead_seg, {SEG_LSB{1'b0}}};
  assign txn_lanes = txn_valid ? hit : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pend_q <= '0;
      seg_q  <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy   <= 1'b1;
        seg_q  <= seg_in;
        pend_q <= req_mask;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else if (txn_ready) begin
      pend_q <= pend_q & ~hit;
    end
  end
endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             txn_valid,
  input logic             txn_ready,
  input logic [AW-1:0]    txn_base,
  input logic [LANES-1:0] txn_lanes,
  input logic             done
);
  localparam int SEG_LSB = $clog2(4 * LANES);

  // R2
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_base[SEG_LSB-1:0] == '0);

  // R3
  lanes_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_lanes != '0);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_lanes)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!txn_valid && !done));
endmodule

bind warp_coalescer warp_coalescer_chk #(.LANES(LANES), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .txn_valid(txn_valid),
  .txn_ready(txn_ready), .txn_base(txn_base), .txn_lanes(txn_lanes), .done(done)
);

// File: tb/warp_coalescer_tb.sv
`timescale 1ns/1ps
module warp_coalescer_tb_top;
  localparam int LANES   = 32;
  localparam int AW      = 32;
  localparam int SEG_LSB = $clog2(4 * LANES);

  logic clk = 0, rst_n = 0, req_valid = 0, txn_ready = 0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES-1:0] req_mask = '0;
  logic req_ready, txn_valid, done;
  logic [AW-1:0] txn_base;
  logic [LANES-1:0] txn_lanes;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] addrs [LANES];
  logic [AW-1:0] exp_base [LANES];
  logic [LANES-1:0] exp_lanes [LANES];
  int exp_n;

  always #2.5 clk = ~clk;

  warp_coalescer #(.LANES(LANES), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_base(txn_base), .txn_lanes(txn_lanes), .done(done));

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, expv);
    end
  endtask

  task automatic build_exp(input logic [LANES-1:0] mask);
    logic [LANES-1:0] pend = mask;
    exp_n = 0;
    while (pend != '0) begin
      int lead = 0;
      logic [LANES-1:0] grp = '0;
      for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
      for (int i = 0; i < LANES; i++)
        if (pend[i] && (addrs[i] >> SEG_LSB) == (addrs[lead] >> SEG_LSB)) grp[i] = 1'b1;
      exp_base[exp_n]  = (addrs[lead] >> SEG_LSB) << SEG_LSB;
      exp_lanes[exp_n] = grp;
      exp_n++;
      pend &= ~grp;
    end
  endtask

  task automatic run(input string r, input logic [LANES-1:0] mask, input bit stall);
    int idx = 0, last_hs = -1;
    build_exp(mask);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready before request", 64'(req_ready), 64'd1);
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = addrs[i];
    req_mask  = mask;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 300; cyc++) begin
      txn_ready = stall ? (cyc % 3 == 2) : 1'b1;
      if (cyc == 0) chk(req_ready == 1'b0, "R10", "ready while busy", 64'(req_ready), 64'd0);
      if (done) begin
        chk(idx == exp_n, r, "transaction count", 64'(idx), 64'(exp_n));
        chk(cyc == last_hs + 1, (exp_n == 0) ? "R7" : "R9", "done cycle",
            64'(cyc), 64'(last_hs + 1));
        break;
      end
      if (txn_valid && txn_ready) begin
        if (idx < exp_n) begin
          chk(txn_base == exp_base[idx], r, "txn_base", 64'(txn_base), 64'(exp_base[idx]));
          chk(txn_lanes == exp_lanes[idx], r, "txn_lanes", 64'(txn_lanes), 64'(exp_lanes[idx]));
        end else begin
          chk(1'b0, r, "extra transaction", 64'(idx), 64'(exp_n));
        end
        idx++;
        last_hs = cyc;
      end
      @(negedge clk);
    end
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R9", "ready after done",
        64'({req_ready, done}), 64'b10);
    txn_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1 && txn_valid == 1'b0 && done == 1'b0, "R1", "reset outputs",
        64'({req_ready, txn_valid, done}), 64'b100);
  endtask

  task automatic t_contig();
    for (int i = 0; i < LANES; i++) addrs[i] = 32'h0000_1000 + 4 * i;
    run("R4", '1, 1'b0);
  endtask

  task automatic t_scatter();
    for (int i = 0; i < LANES; i++) addrs[i] = 32'h0010_0004 + 32'h1000 * (LANES - 1 - i);
    run("R5", '1, 1'b0);
  endtask

  task automatic t_inactive();
    for (int i = 0; i < LANES; i++)
      addrs[i] = (i < LANES / 2) ? 32'h0000_4000 + 4 * i : 32'h0777_0000 + 32'h200 * i;
    run("R6", {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}}, 1'b0);
  endtask

  task automatic t_empty();
    for (int i = 0; i < LANES; i++) addrs[i] = 32'h0000_9000 + 4 * i;
    run("R7", '0, 1'b0);
  endtask

  task automatic t_interleave_stall();
    for (int i = 0; i < LANES; i++)
      addrs[i] = (i % 2 == 0) ? 32'h0000_5000 + 4 * i : 32'h0000_6010 + 4 * i;
    run("R8", '1, 1'b1);
  endtask

  task automatic t_misaligned();
    for (int i = 0; i < LANES; i++) addrs[i] = 32'h0000_2040 + 4 * i;
    run("R2", '1, 1'b0);
  endtask

  task automatic t_lead_order();
    for (int i = 0; i < LANES; i++) addrs[i] = 32'h0000_3000 + 4 * i;
    addrs[0] = 32'h0000_3084;
    addrs[5] = 32'h0000_3090;
    run("R3", 32'hFFFF_FFF3, 1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "R9", "watchdog expired", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_contig();
    t_scatter();
    t_inactive();
    t_empty();
    t_interleave_stall();
    t_misaligned();
    t_lead_order();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule